// File: doc/BRIEF.md
# Address-Window Mean Engine

This block computes the integer mean of a contiguous, inclusive span of a 128-entry by 8-bit register file. A single-cycle start request supplies a lower and an upper address. The engine then walks the span, reading one entry per cycle through a read port with one cycle of latency. It adds up the values and counts the entries, then divides the total by the count in a bit-serial restoring divider.

While the job runs, a busy level is held high. When the quotient is ready, a one-cycle done pulse marks the result on the mean output. That value stays in place until the next job finishes. Start requests that arrive while the engine is busy are dropped. A reversed span, where the lower address is above the upper one, collapses to the single entry at the lower address.

Top module: `window_mean_engine`

## Requirements
- R1: A start pulse sampled while busy is 0 latches first_addr and last_addr, and busy reads 1 in the very next cycle.
- R2: During a job, rf_addr steps upward by one per cycle from the latched first address to the latched upper address, both included, and never leaves that span.
- R3: busy stays 1 from the cycle after the accepted start through the done cycle, and is 0 in the cycle that follows done.
- R4: done is 1 for exactly one cycle per accepted start, and busy is 1 in that cycle.
- R5: In the done cycle, mean equals the sum of the span's entries divided by the entry count, with the remainder discarded. mean keeps that value until the next done.
- R6: If first_addr is greater than last_addr, the span is the single entry at first_addr, so the mean equals that entry.
- R7: A start pulse while busy is 1 has no effect: the running job keeps its latched span and its result.
- R8: The full 128-entry span with every entry at 255 yields a mean of 255, with no overflow in the total or the count.
- R9: A synchronous, active-high reset clears busy, done and mean to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Job request, sampled on a rising edge while idle |
| first_addr | input | 7 | Lower address of the span, included |
| last_addr | input | 7 | Upper address of the span, included |
| rf_addr | output | 7 | Read address to the register file |
| rf_rdata | input | 8 | Read data, valid one cycle after rf_addr |
| busy | output | 1 | High while a job is running |
| done | output | 1 | One-cycle pulse when mean is updated |
| mean | output | 8 | Truncated average of the span |

## Verification
Most internal faults show up at mean within one job. A sequencer that stops one entry early or late, an accumulator that drops the first word after the latency stage, or a divider that is off by one step all produce a wrong quotient on the first done pulse. Spans of many lengths and positions are swept against a closed-form average, so a fault tied to a particular length or position is caught as well. Faults in the controller show up within a cycle or two as a busy level that drops early, a done pulse longer than one cycle, or a stray second start that changes the span. The checker catches these on the cycle they happen.

// File: rtl/wme_pkg.sv
package wme_pkg;

    localparam int RF_ADDR_W = 7;
    localparam int RF_DATA_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_DRAIN,
        ST_LOAD,
        ST_DIV,
        ST_FINISH
    } ctrl_state_t;

    typedef struct packed {
        logic load;
        logic step;
        logic issue;
        logic div_start;
    } ctrl_cmd_t;

    // upper bound of the span after reversed-window collapse
    function automatic logic [RF_ADDR_W-1:0] span_top(
        input logic [RF_ADDR_W-1:0] lo_a,
        input logic [RF_ADDR_W-1:0] hi_a
    );
        return (lo_a > hi_a) ? lo_a : hi_a;
    endfunction

endpackage

// File: rtl/wme_addr_seq.sv
module wme_addr_seq #(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] first_in,
    input  logic [ADDR_W-1:0] last_in,
    output logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] lo,
    output logic [ADDR_W-1:0] hi,
    output logic              at_end
);
    logic [ADDR_W-1:0] cur_q, lo_q, hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
            lo_q  <= '0;
            hi_q  <= '0;
        end else if (load) begin
            cur_q <= first_in;
            lo_q  <= first_in;
            hi_q  <= (first_in > last_in) ? first_in : last_in;
        end else if (step && !at_end) begin
            cur_q <= cur_q + ADDR_W'(1);
        end
    end

    assign at_end = (cur_q == hi_q);
    assign addr   = cur_q;
    assign lo     = lo_q;
    assign hi     = hi_q;
endmodule

// File: rtl/wme_accum.sv
module wme_accum #(
    parameter int DATA_W = 8,
    parameter int SUM_W  = 15,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              add_en,
    input  logic [DATA_W-1:0] data,
    output logic [SUM_W-1:0]  sum,
    output logic [CNT_W-1:0]  cnt
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sum <= '0;
            cnt <= '0;
        end else if (add_en) begin
            sum <= sum + SUM_W'(data);
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/wme_divider.sv
module wme_divider #(
    parameter int NUM_W = 15,
    parameter int DEN_W = 8,
    parameter int OUT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NUM_W-1:0] numer,
    input  logic [DEN_W-1:0] denom,
    output logic [OUT_W-1:0] quot,
    output logic             fin
);
    localparam int STEP_W = $clog2(NUM_W + 1);

    logic              run;
    logic [STEP_W-1:0] left;
    logic [DEN_W-1:0]  rem, den_q;
    logic [NUM_W-1:0]  q;
    logic [DEN_W:0]    trial;
    logic              ge;
    logic [DEN_W-1:0]  diff;

    // shift one dividend bit into the partial remainder and try a subtract
    always_comb begin
        trial = {rem, q[NUM_W-1]};
        ge    = (trial >= {1'b0, den_q});
        diff  = trial[DEN_W-1:0] - den_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run   <= 1'b0;
            left  <= '0;
            rem   <= '0;
            den_q <= '0;
            q     <= '0;
            fin   <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (start) begin
                q     <= numer;
                rem   <= '0;
                den_q <= denom;
                left  <= STEP_W'(NUM_W);
                run   <= 1'b1;
            end else if (run) begin
                rem  <= ge ? diff : trial[DEN_W-1:0];
                q    <= {q[NUM_W-2:0], ge};
                left <= left - STEP_W'(1);
                if (left == STEP_W'(1)) begin
                    run <= 1'b0;
                    fin <= 1'b1;
                end
            end
        end
    end

    assign quot = q[OUT_W-1:0];
endmodule

// File: rtl/wme_ctrl.sv
module wme_ctrl
    import wme_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      at_end,
    input  logic      div_fin,
    output ctrl_cmd_t cmd,
    output logic      rd_vld,
    output logic      capture,
    output logic      busy,
    output logic      done
);
    ctrl_state_t state_q, state_d;

    always_comb begin
        state_d       = state_q;
        cmd           = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    cmd.load = 1'b1;
                    state_d  = ST_READ;
                end
            end
            ST_READ: begin
                cmd.issue = 1'b1;
                cmd.step  = 1'b1;
                if (at_end) state_d = ST_DRAIN;
            end
            ST_DRAIN: state_d = ST_LOAD;
            ST_LOAD: begin
                cmd.div_start = 1'b1;
                state_d       = ST_DIV;
            end
            ST_DIV: begin
                if (div_fin) state_d = ST_FINISH;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            rd_vld  <= 1'b0;
        end else begin
            state_q <= state_d;
            rd_vld  <= cmd.issue;
        end
    end

    assign capture = (state_q == ST_DIV) && div_fin;
    assign busy    = (state_q != ST_IDLE);
    assign done    = (state_q == ST_FINISH);
endmodule

// File: rtl/window_mean_engine.sv
module window_mean_engine
    import wme_pkg::*;
#(
    parameter int ADDR_W = RF_ADDR_W,
    parameter int DATA_W = RF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] first_addr,
    input  logic [ADDR_W-1:0] last_addr,
    output logic [ADDR_W-1:0] rf_addr,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] mean
);
    localparam int CNT_W = ADDR_W + 1;
    localparam int SUM_W = DATA_W + ADDR_W;

    ctrl_cmd_t         cmd;
    logic              rd_vld, capture, at_end, div_fin;
    logic [ADDR_W-1:0] win_lo, win_hi;
    logic [SUM_W-1:0]  acc_sum;
    logic [CNT_W-1:0]  acc_cnt;
    logic [DATA_W-1:0] quot;
    logic [DATA_W-1:0] mean_q;

    wme_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .at_end  (at_end),
        .div_fin (div_fin),
        .cmd     (cmd),
        .rd_vld  (rd_vld),
        .capture (capture),
        .busy    (busy),
        .done    (done)
    );

    wme_addr_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .load     (cmd.load),
        .step     (cmd.step),
        .first_in (first_addr),
        .last_in  (last_addr),
        .addr     (rf_addr),
        .lo       (win_lo),
        .hi       (win_hi),
        .at_end   (at_end)
    );

    wme_accum #(.DATA_W(DATA_W), .SUM_W(SUM_W), .CNT_W(CNT_W)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .clear  (cmd.load),
        .add_en (rd_vld),
        .data   (rf_rdata),
        .sum    (acc_sum),
        .cnt    (acc_cnt)
    );

    wme_divider #(.NUM_W(SUM_W), .DEN_W(CNT_W), .OUT_W(DATA_W)) u_div (
        .clk   (clk),
        .rst   (rst),
        .start (cmd.div_start),
        .numer (acc_sum),
        .denom (acc_cnt),
        .quot  (quot),
        .fin   (div_fin)
    );

    always_ff @(posedge clk) begin
        if (rst)          mean_q <= '0;
        else if (capture) mean_q <= quot;
    end

    assign mean = mean_q;
endmodule

// File: rtl/wme_checker.sv
module wme_checker #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              issue,
    input logic [ADDR_W-1:0] rf_addr,
    input logic [ADDR_W-1:0] win_lo,
    input logic [ADDR_W-1:0] win_hi,
    input logic [ADDR_W:0]   acc_cnt,
    input logic [DATA_W-1:0] mean
);
    // R1
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R2
    addr_window_chk: assert property (@(posedge clk) disable iff (rst)
        issue |-> (rf_addr >= win_lo && rf_addr <= win_hi));

    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (issue && $past(issue)) |-> (rf_addr == $past(rf_addr) + ADDR_W'(1)));

    // R3
    busy_release_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4
    done_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    // R5
    mean_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(mean) |-> done);

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        acc_cnt <= (ADDR_W + 1)'(1 << ADDR_W));
endmodule

bind window_mean_engine wme_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .issue   (cmd.issue),
    .rf_addr (rf_addr),
    .win_lo  (win_lo),
    .win_hi  (win_hi),
    .acc_cnt (acc_cnt),
    .mean    (mean)
);

// File: tb/window_mean_engine_bench.sv
`timescale 1ns/1ps
module window_mean_engine_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [6:0] first_addr = '0;
    logic [6:0] last_addr = '0;
    logic [6:0] rf_addr;
    logic [7:0] rf_rdata = '0;
    logic       busy, done;
    logic [7:0] mean;
    logic [7:0] mem [128];

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    always_ff @(posedge clk) rf_rdata <= mem[rf_addr];

    window_mean_engine u_window_mean_engine (
        .clk(clk), .rst(rst), .start(start), .first_addr(first_addr),
        .last_addr(last_addr), .rf_addr(rf_addr), .rf_rdata(rf_rdata),
        .busy(busy), .done(done), .mean(mean)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int expect_mean(input int f, input int l);
        int hi = (f > l) ? f : l;
        int s = 0;
        for (int i = f; i <= hi; i++) s += mem[i];
        return s / (hi - f + 1);
    endfunction

    // one job; poke issues a second start with another span mid-run
    task automatic run_job(input int f, input int l, input bit poke, input string tag);
        int exp = expect_mean(f, l);
        int cyc = 0;
        bit seen = 0;
        @(negedge clk);
        start = 1'b1; first_addr = 7'(f); last_addr = 7'(l);
        @(negedge clk);
        start = 1'b0; first_addr = 7'(~f); last_addr = 7'(~l);
        chk(busy == 1'b1, "R1 busy after start", int'(busy), 1);
        while (!seen && cyc < 2000) begin
            start = (poke && cyc == 3) ? 1'b1 : 1'b0;
            if (poke && cyc == 3) begin
                first_addr = 7'd0; last_addr = 7'd127;
            end
            @(negedge clk);
            cyc++;
            if (done) seen = 1;
            else if (!busy) begin
                chk(0, "R3 busy dropped before done", 0, 1);
                cyc = 2000;
            end
        end
        start = 1'b0;
        if (!seen) begin
            chk(0, "watchdog no done", 0, 1);
        end else begin
            chk(busy == 1'b1, "R4 busy in done cycle", int'(busy), 1);
            chk(int'(mean) == exp, tag, int'(mean), exp);
            @(negedge clk);
            chk(done == 1'b0, "R4 done single cycle", int'(done), 0);
            chk(busy == 1'b0, "R3 busy after done", int'(busy), 0);
            repeat (3) @(negedge clk);
            chk(int'(mean) == exp, "R5 mean held", int'(mean), exp);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = 8'((i * 37 + 11) % 256);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(busy == 1'b0, "R9 reset busy", int'(busy), 0);
        chk(done == 1'b0, "R9 reset done", int'(done), 0);
        chk(mean == 8'd0, "R9 reset mean", int'(mean), 0);
        rst = 1'b0;

        // R2 R5 sweep of span positions and lengths, reversed ones included
        for (int f = 0; f < 128; f += 7)
            for (int l = 0; l < 128; l += 11)
                run_job(f, l, 0, (f > l) ? "R6 reversed span mean" : "R2 R5 span mean");

        // R6 single-entry and reversed edges
        run_job(127, 0, 0, "R6 reversed at top");
        run_job(0, 0, 0, "R6 single at zero");
        run_job(127, 127, 0, "R2 single at top");

        // R7 start while busy is ignored
        run_job(10, 40, 1, "R7 span kept on restart");
        run_job(90, 20, 1, "R7 reversed span kept on restart");

        // R8 full window at maximum value
        for (int i = 0; i < 128; i++) mem[i] = 8'hFF;
        run_job(0, 127, 0, "R8 full window max");
        for (int i = 0; i < 128; i++) mem[i] = 8'(i);
        run_job(0, 127, 0, "R5 full ramp");
        run_job(3, 4, 0, "R5 truncation");
        for (int i = 0; i < 128; i++) mem[i] = 8'd0;
        run_job(5, 100, 0, "R5 all zero");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule